// File: doc/BRIEF.md
# Timing Event Capture and Interrupt Unit

This block watches a stream of already-decoded 8-bit timing event codes, each presented with a one-cycle valid strobe. It keeps a sticky "seen" flag for every one of the 256 possible codes. The flags are packed sixteen consecutive codes to a 16-bit word, so that software can poll which events have occurred since it last cleared them.

Sixteen programmable match slots, each with its own arm bit, select the events that should interrupt the host. A matching event raises an interrupt pending flag and records its code as the last interrupting event. It also bumps a saturating count of interrupting events not yet read. An interrupt status word carries a vector, the pending flag, a level field, an enable and two auto-clear controls. A separate programmable code latches a 64-bit free-running time value supplied on an input, and the latched value is readable as four 16-bit words.

Access is through a simple word-wide register write port and a register read port. Read data is registered.

Top module: `evt_capture_irq`

## Requirements
- R1: A valid event with code C sets found flag C, held in word C[7:4] (address 0x00 + C[7:4]) at bit C[3:0]; a flag once set stays set until cleared.
- R2: Writing a found word (addresses 0x00 to 0x0F) clears exactly the flags whose data bits are 1; bits written 0 are untouched, and a set in the same cycle wins.
- R3: Slot i's code is read and written at address 0x10+i (bits 7:0), and the arm mask is at 0x20 (bit i arms slot i). A valid event equal to an armed slot's code, while the enable is 1, sets the pending flag in that clock edge. An event on no armed slot, or any event while the enable is 0, leaves pending, the last-event register and the count unchanged.
- R4: Address 0x22 (read-only, bits 7:0) returns the code of the most recent interrupting event.
- R5: Address 0x23 returns the count of interrupting events. It increments on each one and saturates at 255. Each read of 0x22 decrements it, and it does not go below 0.
- R6: Status word at 0x21: bits 7:0 vector, bit 8 pending (read-only), bit 9 flag auto-clear, bits 12:10 level, bit 13 interrupt auto-clear, bit 14 enable. irq_o = pending AND enable. irq_level_o equals the level field while irq_o is 1, otherwise 0.
- R7: With flag auto-clear set, a read of 0x21 returns the pending bit as it was and then clears it.
- R8: With interrupt auto-clear set, a read of 0x22 clears the pending flag.
- R9: Writing 1 to bit 0 of the control address 0x24 clears the pending flag; a new interrupting event in the same cycle wins.
- R10: Address 0x25 holds the timestamp event code (bits 7:0) and its enable (bit 8). A valid event with that code, while enabled, latches ts_in. The latched value reads at 0x26 to 0x29, lowest 16 bits first. Other events leave it unchanged.
- R11: After reset all flags, codes, mask, status fields, count, last code and timestamp are 0, and irq_o is 0.
- R12: rd_data holds the value addressed by a read in the cycle after rd_en; unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event code strobe |
| evt_code | input | 8 | Decoded event code |
| ts_in | input | 64 | Free-running time value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 6 | Register read address |
| rd_data | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt request |
| irq_level_o | output | 3 | Interrupt level while requesting |

## Verification
Every state update, including found flags, pending, count, last code and timestamp, lands on the same clock edge that samples the event or register access. irq_o is decoded from registers, so it is due right after that edge. Read data appears one edge after rd_en, and read side effects such as auto-clear and count decrement take effect on that same edge. The bench drives inputs at the falling edge and samples one nanosecond after the rising edge that completes each access, so each value is compared in the cycle it becomes due.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
  localparam int DW     = 16;
  localparam int AW     = 6;
  localparam int CNT_W  = 8;

  localparam logic [AW-1:0] A_CODE0 = 6'h10;
  localparam logic [AW-1:0] A_ARM   = 6'h20;
  localparam logic [AW-1:0] A_STAT  = 6'h21;
  localparam logic [AW-1:0] A_LAST  = 6'h22;
  localparam logic [AW-1:0] A_CNT   = 6'h23;
  localparam logic [AW-1:0] A_CTL   = 6'h24;
  localparam logic [AW-1:0] A_TSCFG = 6'h25;
  localparam logic [AW-1:0] A_TS0   = 6'h26;

  // status word bit positions
  localparam int SB_PEND = 8;
  localparam int SB_FAC  = 9;
  localparam int SB_LVL  = 10;
  localparam int SB_IAC  = 13;
  localparam int SB_EN   = 14;

  // saturating up/down step of the pending-event count
  function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] c,
                                                input logic inc, input logic dec);
    logic [CNT_W-1:0] top;
    top = '1;
    if (inc && !dec) return (c == top) ? c : c + 1'b1;
    if (dec && !inc) return (c == '0) ? c : c - 1'b1;
    return c;
  endfunction
endpackage

// File: rtl/evt_found_map.sv
module evt_found_map #(
  parameter int CODE_W = 8,
  parameter int DW     = 16,
  localparam int NCODES = 1 << CODE_W,
  localparam int NWORDS = NCODES / DW,
  localparam int WIX_W  = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [CODE_W-1:0] evt_code,
  input  logic              clr_en,
  input  logic [WIX_W-1:0]  clr_word,
  input  logic [DW-1:0]     clr_mask,
  input  logic [WIX_W-1:0]  rd_word,
  output logic [DW-1:0]     rd_val
);
  logic [NCODES-1:0] flags;
  logic [NCODES-1:0] set_vec;
  logic [NCODES-1:0] clr_vec;

  always_comb begin
    set_vec = '0;
    if (evt_valid) set_vec[evt_code] = 1'b1;
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_clr
    assign clr_vec[w*DW +: DW] = (clr_en && clr_word == WIX_W'(w)) ? clr_mask : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_vec) | set_vec;
  end

  assign rd_val = flags[rd_word*DW +: DW];

  AST_FOUND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> ((flags & $past(flags)) == $past(flags))); // R1
  AST_FOUND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> flags[$past(evt_code)]); // R1
endmodule

// File: rtl/evt_match_table.sv
module evt_match_table #(
  parameter int NSLOT  = 16,
  parameter int CODE_W = 8,
  localparam int SIX_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_we,
  input  logic [SIX_W-1:0]  code_idx,
  input  logic [CODE_W-1:0] code_wd,
  input  logic              arm_we,
  input  logic [NSLOT-1:0]  arm_wd,
  input  logic              evt_valid,
  input  logic [CODE_W-1:0] evt_code,
  input  logic [SIX_W-1:0]  rd_idx,
  output logic [CODE_W-1:0] rd_code,
  output logic [NSLOT-1:0]  arm_q,
  output logic              match_o
);
  logic [CODE_W-1:0] codes [NSLOT];
  logic [NSLOT-1:0]  eq;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                codes[s] <= '0;
      else if (code_we && code_idx == SIX_W'(s)) codes[s] <= code_wd;
    end
    assign eq[s] = (codes[s] == evt_code);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      arm_q <= '0;
    else if (arm_we) arm_q <= arm_wd;
  end

  assign match_o = evt_valid && |(eq & arm_q);
  assign rd_code = codes[rd_idx];

  AST_NO_MATCH_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q == '0) |-> !match_o); // R3
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evcap_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              match_i,
  input  logic [CODE_W-1:0] evt_code,
  input  logic              stat_we,
  input  logic [DW-1:0]     stat_wd,
  input  logic              ctl_clr,
  input  logic              rd_stat,
  input  logic              rd_last,
  output logic [DW-1:0]     stat_q,
  output logic [CODE_W-1:0] last_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              hit_o,
  output logic              irq_o,
  output logic [2:0]        irq_level_o
);
  logic [7:0] vec;
  logic [2:0] lvl;
  logic       pend, fac, iac, en;
  logic       pend_clr;

  assign hit_o    = match_i && en;
  assign pend_clr = ctl_clr || (rd_stat && fac) || (rd_last && iac);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec <= '0; lvl <= '0; pend <= 1'b0; fac <= 1'b0; iac <= 1'b0; en <= 1'b0;
      last_q <= '0; cnt_q <= '0;
    end else begin
      if (stat_we) begin
        vec <= stat_wd[7:0];
        fac <= stat_wd[SB_FAC];
        lvl <= stat_wd[SB_LVL +: 3];
        iac <= stat_wd[SB_IAC];
        en  <= stat_wd[SB_EN];
      end
      if (hit_o)         pend <= 1'b1;
      else if (pend_clr) pend <= 1'b0;
      if (hit_o) last_q <= evt_code;
      cnt_q <= sat_step(cnt_q, hit_o, rd_last);
    end
  end

  assign stat_q      = {1'b0, en, iac, lvl, fac, pend, vec};
  assign irq_o       = pend && en;
  assign irq_level_o = irq_o ? lvl : 3'd0;

  AST_PEND_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> pend); // R3
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '1 && hit_o && !rd_last) |=> cnt_q == '1); // R5
  AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_last && !hit_o && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R5
  AST_LEVEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> irq_level_o == 3'd0); // R6
  AST_CTL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_clr && !hit_o) |=> !pend); // R9
endmodule

// File: rtl/evt_ts_latch.sv
module evt_ts_latch #(
  parameter int CODE_W = 8,
  parameter int TS_W   = 64,
  parameter int DW     = 16,
  localparam int NW    = TS_W / DW,
  localparam int WIX_W = $clog2(NW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DW-1:0]     cfg_wd,
  input  logic              evt_valid,
  input  logic [CODE_W-1:0] evt_code,
  input  logic [TS_W-1:0]   ts_in,
  input  logic [WIX_W-1:0]  rd_word,
  output logic [DW-1:0]     cfg_q,
  output logic [DW-1:0]     rd_val
);
  logic [CODE_W-1:0] ts_code;
  logic              ts_en;
  logic [TS_W-1:0]   ts_q;
  logic              ts_hit;

  assign ts_hit = evt_valid && ts_en && (evt_code == ts_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_code <= '0; ts_en <= 1'b0; ts_q <= '0;
    end else begin
      if (cfg_we) begin
        ts_code <= cfg_wd[CODE_W-1:0];
        ts_en   <= cfg_wd[CODE_W];
      end
      if (ts_hit) ts_q <= ts_in;
    end
  end

  assign cfg_q  = DW'({ts_en, ts_code});
  assign rd_val = ts_q[rd_word*DW +: DW];

  AST_TS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ts_hit |=> ts_q == $past(ts_in)); // R10
  AST_TS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ts_hit |=> $stable(ts_q)); // R10
endmodule

// File: rtl/evt_capture_irq.sv
module evt_capture_irq
  import evcap_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int NSLOT  = 16,
  parameter int TS_W   = 64,
  localparam int FW_W  = $clog2((1 << CODE_W) / DW),
  localparam int SIX_W = $clog2(NSLOT),
  localparam int TW_W  = $clog2(TS_W / DW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [CODE_W-1:0] evt_code,
  input  logic [TS_W-1:0]   ts_in,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              irq_o,
  output logic [2:0]        irq_level_o
);
  // write decode
  logic wr_found, wr_code, wr_arm, wr_stat, wr_ctl, wr_tscfg;
  assign wr_found = wr_en && (wr_addr[AW-1:FW_W] == '0);
  assign wr_code  = wr_en && (wr_addr[AW-1:SIX_W] == A_CODE0[AW-1:SIX_W]);
  assign wr_arm   = wr_en && (wr_addr == A_ARM);
  assign wr_stat  = wr_en && (wr_addr == A_STAT);
  assign wr_ctl   = wr_en && (wr_addr == A_CTL) && wr_data[0];
  assign wr_tscfg = wr_en && (wr_addr == A_TSCFG);

  // read side effects
  logic rd_stat, rd_last;
  assign rd_stat = rd_en && (rd_addr == A_STAT);
  assign rd_last = rd_en && (rd_addr == A_LAST);

  logic [DW-1:0]     found_rd, stat_q, tscfg_q, ts_rd;
  logic [CODE_W-1:0] code_rd, last_q;
  logic [NSLOT-1:0]  arm_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              match, hit;
  logic [AW-1:0]     ts_off;
  assign ts_off = rd_addr - A_TS0;

  evt_found_map #(.CODE_W(CODE_W), .DW(DW)) found_i (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
    .clr_en(wr_found), .clr_word(wr_addr[FW_W-1:0]), .clr_mask(wr_data),
    .rd_word(rd_addr[FW_W-1:0]), .rd_val(found_rd));

  evt_match_table #(.NSLOT(NSLOT), .CODE_W(CODE_W)) match_i (
    .clk(clk), .rst_n(rst_n), .code_we(wr_code), .code_idx(wr_addr[SIX_W-1:0]),
    .code_wd(wr_data[CODE_W-1:0]), .arm_we(wr_arm), .arm_wd(wr_data[NSLOT-1:0]),
    .evt_valid(evt_valid), .evt_code(evt_code), .rd_idx(rd_addr[SIX_W-1:0]),
    .rd_code(code_rd), .arm_q(arm_q), .match_o(match));

  evt_irq_ctrl #(.CODE_W(CODE_W)) irq_i (
    .clk(clk), .rst_n(rst_n), .match_i(match), .evt_code(evt_code),
    .stat_we(wr_stat), .stat_wd(wr_data), .ctl_clr(wr_ctl),
    .rd_stat(rd_stat), .rd_last(rd_last), .stat_q(stat_q), .last_q(last_q),
    .cnt_q(cnt_q), .hit_o(hit), .irq_o(irq_o), .irq_level_o(irq_level_o));

  evt_ts_latch #(.CODE_W(CODE_W), .TS_W(TS_W), .DW(DW)) ts_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(wr_tscfg), .cfg_wd(wr_data),
    .evt_valid(evt_valid), .evt_code(evt_code), .ts_in(ts_in),
    .rd_word(ts_off[TW_W-1:0]), .cfg_q(tscfg_q), .rd_val(ts_rd));

  // read mux
  logic [DW-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (rd_addr[AW-1:FW_W] == '0)                          rd_next = found_rd;
    else if (rd_addr[AW-1:SIX_W] == A_CODE0[AW-1:SIX_W])   rd_next = DW'(code_rd);
    else if (rd_addr == A_ARM)                             rd_next = DW'(arm_q);
    else if (rd_addr == A_STAT)                            rd_next = stat_q;
    else if (rd_addr == A_LAST)                            rd_next = DW'(last_q);
    else if (rd_addr == A_CNT)                             rd_next = DW'(cnt_q);
    else if (rd_addr == A_TSCFG)                           rd_next = tscfg_q;
    else if (rd_addr >= A_TS0 && ts_off < AW'(TS_W / DW))  rd_next = ts_rd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> stat_q[SB_PEND] && stat_q[SB_EN]); // R6
  AST_HIT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> irq_o); // R3
endmodule

// File: tb/evt_capture_irq_tb.sv
module evt_capture_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [7:0]  evt_code = '0;
  logic [63:0] ts_in = '0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        irq_o;
  logic [2:0]  irq_level_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  evt_capture_irq dut_i (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
    .ts_in(ts_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_o(irq_o), .irq_level_o(irq_level_o));

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(posedge clk); #1; d = rd_data; rd_en = 1'b0;
  endtask

  task automatic ev(input logic [7:0] c);
    @(negedge clk); evt_valid = 1'b1; evt_code = c;
    @(posedge clk); #1; evt_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    do_reset();
    #1 chk("R11 irq after reset", {15'd0, irq_o}, 16'd0);
    rd(6'h21, d); chk("R11 status after reset", d, 16'h0000);
    rd(6'h23, d); chk("R11 count after reset", d, 16'h0000);
    rd(6'h00, d); chk("R11 found word 0 after reset", d, 16'h0000);
  endtask

  task automatic t_found();
    logic [15:0] d;
    do_reset();
    ev(8'h00); ev(8'h0F); ev(8'h10); ev(8'hFF); ev(8'h37);
    rd(6'h00, d); chk("R1 found word 0", d, 16'h8001);
    rd(6'h01, d); chk("R1 found word 1", d, 16'h0001);
    rd(6'h03, d); chk("R1 found word 3", d, 16'h0080);
    rd(6'h0F, d); chk("R1 found word 15", d, 16'h8000);
    ev(8'h00);
    rd(6'h00, d); chk("R1 sticky after repeat", d, 16'h8001);
    wr(6'h00, 16'h0001);
    rd(6'h00, d); chk("R2 w1c clears only bit 0", d, 16'h8000);
    rd(6'h3F, d); chk("R12 unmapped reads zero", d, 16'h0000);
  endtask

  task automatic t_match();
    logic [15:0] d;
    do_reset();
    wr(6'h12, 16'h0033);
    wr(6'h20, 16'h0004);
    rd(6'h12, d); chk("R3 slot code readback", d, 16'h0033);
    ev(8'h33);
    chk("R3 enable 0 blocks irq", {15'd0, irq_o}, 16'd0);
    rd(6'h23, d); chk("R3 enable 0 leaves count", d, 16'h0000);
    wr(6'h21, 16'h4000);
    ev(8'h34);
    chk("R3 non-matching event no irq", {15'd0, irq_o}, 16'd0);
    wr(6'h12, 16'h0034); wr(6'h20, 16'h0000);
    ev(8'h34);
    chk("R3 unarmed slot no irq", {15'd0, irq_o}, 16'd0);
    wr(6'h20, 16'h0004);
    ev(8'h34);
    chk("R3 armed match raises irq", {15'd0, irq_o}, 16'd1);
    rd(6'h22, d); chk("R4 last event code", d, 16'h0034);
    rd(6'h23, d); chk("R5 count after read of last", d, 16'h0000);
    chk("R8 no auto-clear keeps irq", {15'd0, irq_o}, 16'd1);
    wr(6'h24, 16'h0001);
    chk("R9 control clear drops irq", {15'd0, irq_o}, 16'd0);
  endtask

  task automatic t_flag_ac();
    logic [15:0] d;
    do_reset();
    wr(6'h10, 16'h0055); wr(6'h20, 16'h0001);
    wr(6'h21, 16'h4E5A);
    ev(8'h55);
    chk("R6 irq level while requesting", {13'd0, irq_level_o}, 16'd3);
    rd(6'h21, d); chk("R7 status read shows pending", d, 16'h4F5A);
    chk("R7 pending cleared by status read", {15'd0, irq_o}, 16'd0);
    chk("R6 level zero when idle", {13'd0, irq_level_o}, 16'd0);
    rd(6'h21, d); chk("R7 status after auto-clear", d, 16'h4E5A);
  endtask

  task automatic t_int_ac();
    logic [15:0] d;
    do_reset();
    wr(6'h1F, 16'h00C1); wr(6'h20, 16'h8000);
    wr(6'h21, 16'h6000);
    ev(8'hC1); ev(8'hC1);
    rd(6'h23, d); chk("R5 count of two events", d, 16'h0002);
    rd(6'h22, d); chk("R4 last code slot 15", d, 16'h00C1);
    chk("R8 last read clears pending", {15'd0, irq_o}, 16'd0);
    rd(6'h23, d); chk("R5 count decremented", d, 16'h0001);
  endtask

  task automatic t_sat();
    logic [15:0] d;
    do_reset();
    wr(6'h10, 16'h0044); wr(6'h20, 16'h0001); wr(6'h21, 16'h4000);
    for (int i = 0; i < 260; i++) ev(8'h44);
    rd(6'h23, d); chk("R5 count saturates at 255", d, 16'h00FF);
    rd(6'h22, d);
    rd(6'h23, d); chk("R5 decrement from saturation", d, 16'h00FE);
    do_reset();
    rd(6'h22, d);
    rd(6'h23, d); chk("R5 no decrement below zero", d, 16'h0000);
  endtask

  task automatic t_ts();
    logic [15:0] d;
    do_reset();
    wr(6'h25, 16'h01A5);
    rd(6'h25, d); chk("R10 timestamp config readback", d, 16'h01A5);
    ts_in = 64'h1122_3344_5566_7788;
    ev(8'hA5);
    ts_in = 64'hDEAD_BEEF_0000_9999;
    ev(8'h11);
    rd(6'h26, d); chk("R10 ts word 0", d, 16'h7788);
    rd(6'h27, d); chk("R10 ts word 1", d, 16'h5566);
    rd(6'h28, d); chk("R10 ts word 2", d, 16'h3344);
    rd(6'h29, d); chk("R10 ts word 3", d, 16'h1122);
    rd(6'h2A, d); chk("R12 past last ts word reads zero", d, 16'h0000);
  endtask

  initial begin
    t_reset();
    t_found();
    t_match();
    t_flag_ac();
    t_int_ac();
    t_sat();
    t_ts();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule